// File: doc/BRIEF.md
# Serial Trim Register with Non-Volatile Backup

This block is a serial-bus slave that stores a 7-bit trim code for an analog current DAC. The code sits in a working register that drives the DAC pins directly. A modelled non-volatile cell sits beside it, and the working register is refilled from that cell whenever the logic comes out of reset. A bus master changes the code with a single-byte write and reads it back with a single-byte read. In a production line the code is tuned by writing it to the volatile register only. Once the right value is found, it is committed to the non-volatile cell.

Every transfer carries exactly one data byte. The upper seven bits of that byte hold the code, most significant bit first. The lowest bit is a control/status flag. On a write, this flag chooses between a volatile-only update and an update that also programs the non-volatile cell. On a read, it reports whether a programming cycle is still running. Programming the non-volatile cell is allowed only while the write-enable pin is high. A programming cycle lasts a parameterised number of system clocks. The bus lines are sampled through synchronisers on a system clock that runs at least eight times faster than SCL.

Top module: `trim_cal_top`

## Requirements
- R1: The slave answers only the 7-bit address 1001111, so the address byte is 0x9E for a write and 0x9F for a read. A byte with any other address gets no acknowledge, and the slave ignores the bus until the next START.
- R2: A START (SDA falling while SCL is high) begins the address phase. This holds even in the middle of a transfer. A STOP (SDA rising while SCL is high) ends the transfer and releases SDA.
- R3: The slave pulls SDA low for the ninth clock after the address byte and after the write data byte. It changes its SDA drive only while SCL is low.
- R4: In a write, data bits 7:1 carry the code and bit 0 is the flag. With the flag at 1, only the working register takes the code, and no non-volatile cycle starts.
- R5: A write with the flag at 0 while the write-enable pin is high and no cycle is running does three things. It loads the working register, marks programming busy for NV_PROG_CYCLES clocks, and then leaves the code in the non-volatile cell.
- R6: A read returns the current code in bits 7:1, most significant bit first. Bit 0 is 1 when programming is idle and 0 while it is busy.
- R7: With the write-enable pin low, a write with the flag at 0 is still acknowledged and still loads the working register, but no non-volatile cycle starts.
- R8: While programming is busy, a write with the flag at 0 loads the working register but its non-volatile request is dropped. A write with the flag at 1 is accepted as usual.
- R9: While rst_n is low, code_valid is low. One clock after release, the working register holds the non-volatile contents and code_valid is high. The non-volatile contents survive rst_n.
- R10: After por_n, the non-volatile cell holds NV_INIT.
- R11: Only one data byte is taken per write. Any further byte in the same transfer gets no acknowledge and is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| por_n | input | 1 | Power-on reset of the non-volatile cell model, active low |
| rst_n | input | 1 | Logic reset, active low; release reloads the code from the cell |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Open-drain drive: 1 pulls SDA low |
| nv_wr_en | input | 1 | High allows non-volatile programming |
| dac_code | output | 7 | Trim code to the DAC |
| code_valid | output | 1 | Code has been loaded after reset |

## Verification
The main function is tested with several kinds of transfer. Writes with the flag at 1 and at 0 are followed by reads and by a logic reset; the reset tells a volatile update apart from a committed one. The same flag-0 write is repeated with the enable pin low and again while a cycle is busy, which separates the blocked, dropped and accepted cases in the cell contents. The codes 0x00 and 0x7F, a wrong address, an address one bit away, an extra data byte, an early STOP and a repeated START check the address decode, the single-byte rule and the framing.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int TRIM_W = 7;
  localparam int BYTE_W = TRIM_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_HOLD
  } bus_st_t;

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [TRIM_W-1:0] own);
    return b[BYTE_W-1:1] == own;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(input logic [TRIM_W-1:0] code,
                                                    input logic busy);
    return {code, ~busy};
  endfunction
endpackage

// File: rtl/trim_edge_sync.sv
module trim_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_q     <= scl_chain[STAGES-1];
      sda_q     <= sda_chain[STAGES-1];
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & ~sda_s & sda_q;
  assign stop_det  = scl_s & scl_q & sda_s & ~sda_q;
endmodule

// File: rtl/trim_nv_model.sv
module trim_nv_model #(
  parameter int          W              = 7,
  parameter int          NV_PROG_CYCLES = 50_000_000,
  parameter logic [W-1:0] NV_INIT       = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         req,
  input  logic [W-1:0] din,
  output logic         busy,
  output logic [W-1:0] q
);
  localparam int CW = $clog2(NV_PROG_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  pend;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      pend <= NV_INIT;
      q    <= NV_INIT;
    end else if (req && !busy) begin
      pend <= din;
      cnt  <= CW'(NV_PROG_CYCLES);
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
        q    <= pend;
        cnt  <= '0;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  a_r5_commit_at_end: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(q) |-> $fell(busy));
  a_r8_busy_keeps_pending: assert property (@(posedge clk) disable iff (!por_n)
    (busy && req) |=> $stable(pend));
endmodule

// File: rtl/trim_bus_engine.sv
module trim_bus_engine
  import trim_pkg::*;
#(
  parameter logic [TRIM_W-1:0] SLAVE_ADDR = 7'b1001111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [TRIM_W-1:0] cur_code,
  input  logic              nv_busy,
  input  logic              wr_enable,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [TRIM_W-1:0] wr_code,
  output logic              wr_p,
  output logic              nv_req
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  bus_st_t           st;
  logic [CNT_W-1:0]  cnt;
  logic [TRIM_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic              rw, ack_on;
  logic [BYTE_W-1:0] rx_byte;

  assign rx_byte = {sh, sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0; rw <= 1'b0; ack_on <= 1'b0;
      sda_oe <= 1'b0; wr_stb <= 1'b0; wr_code <= '0; wr_p <= 1'b0; nv_req <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      nv_req <= 1'b0;
      if (start_det) begin
        st <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0; ack_on <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; sda_oe <= 1'b0; ack_on <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: if (scl_rise) begin
            sh <= rx_byte[TRIM_W-1:0];
            if (cnt == LAST) begin
              cnt <= '0;
              if (addr_hit(rx_byte, SLAVE_ADDR)) begin
                rw <= sda_s;
                st <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end else cnt <= cnt + CNT_W'(1);
          end
          ST_AACK: if (scl_fall) begin
            if (!ack_on) begin
              sda_oe <= 1'b1; ack_on <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              if (rw) begin
                tx     <= pack_status(cur_code, nv_busy);
                sda_oe <= ~pack_status(cur_code, nv_busy)[BYTE_W-1];
                st     <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_WDAT;
              end
            end
          end
          ST_WDAT: if (scl_rise) begin
            sh <= rx_byte[TRIM_W-1:0];
            if (cnt == LAST) begin
              cnt     <= '0;
              wr_stb  <= 1'b1;
              wr_code <= rx_byte[BYTE_W-1:1];
              wr_p    <= rx_byte[0];
              nv_req  <= ~rx_byte[0] & wr_enable;
              st      <= ST_WACK;
            end else cnt <= cnt + CNT_W'(1);
          end
          ST_WACK: if (scl_fall) begin
            if (!ack_on) begin
              sda_oe <= 1'b1; ack_on <= 1'b1;
            end else begin
              sda_oe <= 1'b0; ack_on <= 1'b0; st <= ST_HOLD;
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              if (cnt == LAST) begin
                cnt <= '0; st <= ST_RACK;
              end else cnt <= cnt + CNT_W'(1);
            end else if (scl_fall) begin
              tx     <= {tx[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx[BYTE_W-2];
            end
          end
          ST_RACK: if (scl_fall) begin
            sda_oe <= 1'b0; st <= ST_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  a_r3_drive_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

// File: rtl/trim_cal_top.sv
module trim_cal_top
  import trim_pkg::*;
#(
  parameter logic [TRIM_W-1:0] SLAVE_ADDR     = 7'b1001111,
  parameter int                NV_PROG_CYCLES = 50_000_000,
  parameter logic [TRIM_W-1:0] NV_INIT        = 7'h40,
  parameter int                SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              nv_wr_en,
  output logic [TRIM_W-1:0] dac_code,
  output logic              code_valid
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_stb, wr_p, nv_req, nv_busy;
  logic [TRIM_W-1:0] wr_code, nv_q, dac_q;
  logic valid_q;

  trim_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i, .scl_s, .sda_s,
    .scl_rise, .scl_fall, .start_det, .stop_det
  );

  trim_bus_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_eng (
    .clk, .rst_n, .scl_s, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det,
    .cur_code(dac_q), .nv_busy, .wr_enable(nv_wr_en), .sda_oe,
    .wr_stb, .wr_code, .wr_p, .nv_req
  );

  trim_nv_model #(.W(TRIM_W), .NV_PROG_CYCLES(NV_PROG_CYCLES), .NV_INIT(NV_INIT)) u_nv (
    .clk, .por_n, .req(nv_req), .din(wr_code), .busy(nv_busy), .q(nv_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q   <= '0;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      dac_q   <= nv_q;
      valid_q <= 1'b1;
    end else if (wr_stb) begin
      dac_q <= wr_code;
    end
  end

  assign dac_code   = dac_q;
  assign code_valid = valid_q;

  a_r9_reload_from_nv: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !code_valid |=> (dac_code == $past(nv_q)));
  a_r7_wp_gates_program: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(nv_busy) |-> $past(nv_wr_en));
  a_r4_volatile_no_program: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (wr_stb && wr_p) |=> !$rose(nv_busy));
endmodule

// File: tb/tb_trim_cal_top.sv
module tb_trim_cal_top;
  localparam int Q = 8;
  localparam int H = 16;
  localparam int PROG = 4000;
  localparam logic [6:0] INIT = 7'h2A;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, scl = 1'b1, tb_low = 1'b0, wen = 1'b0;
  logic sda_oe, code_valid;
  logic [6:0] dac_code;
  wire sda_line = ~(sda_oe | tb_low);
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trim_cal_top #(.NV_PROG_CYCLES(PROG), .NV_INIT(INIT)) dut (
    .clk, .por_n, .rst_n, .scl_i(scl), .sda_i(sda_line), .sda_oe,
    .nv_wr_en(wen), .dac_code, .code_valid
  );

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    tb_low = 1'b0; wt(Q); scl = 1'b1; wt(Q); tb_low = 1'b1; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop;
    tb_low = 1'b1; wt(Q); scl = 1'b1; wt(Q); tb_low = 1'b0; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tb_low = ~b[i]; wt(Q); scl = 1'b1; wt(H); scl = 1'b0; wt(Q);
    end
    tb_low = 1'b0; wt(Q); scl = 1'b1; wt(Q); ack = ~sda_line; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tb_low = 1'b0; wt(Q); scl = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl = 1'b0; wt(Q);
    end
    tb_low = 1'b0; wt(Q); scl = 1'b1; wt(H); scl = 1'b0; wt(Q);
  endtask

  task automatic wr_xfer(input logic [7:0] a, input logic [7:0] d,
                         output logic aa, output logic ad);
    bus_start; send_byte(a, aa); send_byte(d, ad); bus_stop;
  endtask

  task automatic rd_xfer(output logic aa, output logic [7:0] d);
    bus_start; send_byte(8'h9F, aa); recv_byte(d); bus_stop;
  endtask

  task automatic logic_reset(input logic [6:0] exp);
    rst_n = 1'b0; wt(3);
    chk(code_valid == 1'b0, "R9 valid low in reset", code_valid, 0);
    rst_n = 1'b1; wt(3);
    chk(code_valid == 1'b1, "R9 valid after reset", code_valid, 1);
    chk(dac_code == exp, "R9 code reloaded from cell", dac_code, exp);
  endtask

  task automatic t_power_up;
    wt(5); por_n = 1'b1; wt(3);
    chk(code_valid == 1'b0 && sda_oe == 1'b0, "R9 reset state", {code_valid, sda_oe}, 0);
    rst_n = 1'b1; wt(3);
    chk(dac_code == INIT, "R10 power-up code", dac_code, INIT);
    chk(code_valid == 1'b1, "R9 valid", code_valid, 1);
  endtask

  task automatic t_bad_address;
    logic aa, ad;
    wr_xfer(8'hA0, 8'h0B, aa, ad);
    chk(aa == 1'b0, "R1 foreign address nack", aa, 0);
    wr_xfer(8'h9C, 8'h0B, aa, ad);
    chk(aa == 1'b0 && ad == 1'b0, "R1 near address nack", {aa, ad}, 0);
    chk(dac_code == INIT, "R1 code untouched", dac_code, INIT);
  endtask

  task automatic t_volatile;
    logic aa, ad; logic [7:0] d;
    wr_xfer(8'h9E, {7'h55, 1'b1}, aa, ad);
    chk(aa && ad, "R3 ack address and data", {aa, ad}, 3);
    chk(dac_code == 7'h55, "R4 volatile write", dac_code, 7'h55);
    rd_xfer(aa, d);
    chk(aa == 1'b1, "R1 read address ack", aa, 1);
    chk(d == {7'h55, 1'b1}, "R6 read code and idle flag", d, {7'h55, 1'b1});
    wr_xfer(8'h9E, {7'h00, 1'b1}, aa, ad);
    rd_xfer(aa, d);
    chk(d == 8'h01, "R6 read code zero", d, 8'h01);
    logic_reset(INIT);
  endtask

  task automatic t_write_protect;
    logic aa, ad; logic [7:0] d;
    wen = 1'b0;
    wr_xfer(8'h9E, {7'h11, 1'b0}, aa, ad);
    chk(aa && ad, "R7 acked while protected", {aa, ad}, 3);
    chk(dac_code == 7'h11, "R7 working register loaded", dac_code, 7'h11);
    rd_xfer(aa, d);
    chk(d[0] == 1'b1, "R7 no cycle started", d[0], 1);
    logic_reset(INIT);
  endtask

  task automatic t_program;
    logic aa, ad; logic [7:0] d;
    wen = 1'b1;
    wr_xfer(8'h9E, {7'h33, 1'b0}, aa, ad);
    chk(dac_code == 7'h33, "R5 working register loaded", dac_code, 7'h33);
    rd_xfer(aa, d);
    chk(d == {7'h33, 1'b0}, "R5 R6 busy flag during cycle", d, {7'h33, 1'b0});
    wr_xfer(8'h9E, {7'h44, 1'b0}, aa, ad);
    chk(dac_code == 7'h44 && ad, "R8 flag0 while busy loads register", dac_code, 7'h44);
    wr_xfer(8'h9E, {7'h45, 1'b1}, aa, ad);
    chk(dac_code == 7'h45, "R8 flag1 while busy accepted", dac_code, 7'h45);
    wt(PROG + 200);
    rd_xfer(aa, d);
    chk(d == {7'h45, 1'b1}, "R5 idle after cycle", d, {7'h45, 1'b1});
    logic_reset(7'h33);
    wr_xfer(8'h9E, {7'h7F, 1'b0}, aa, ad);
    wt(PROG + 200);
    wr_xfer(8'h9E, {7'h01, 1'b1}, aa, ad);
    logic_reset(7'h7F);
    wen = 1'b0;
  endtask

  task automatic t_extra_byte;
    logic aa, a1, a2;
    bus_start; send_byte(8'h9E, aa); send_byte({7'h05, 1'b1}, a1);
    send_byte({7'h6E, 1'b1}, a2); bus_stop;
    chk(a1 == 1'b1 && a2 == 1'b0, "R11 second byte nack", {a1, a2}, 2);
    chk(dac_code == 7'h05, "R11 second byte not applied", dac_code, 7'h05);
  endtask

  task automatic t_framing;
    logic aa, ad; logic [7:0] d;
    bus_start; send_byte(8'h9E, aa); bus_stop;
    chk(sda_oe == 1'b0 && dac_code == 7'h05, "R2 stop after address", {sda_oe, dac_code}, 7'h05);
    bus_start; send_byte(8'h9E, aa);
    bus_start; send_byte(8'h9F, aa); recv_byte(d); bus_stop;
    chk(aa == 1'b1 && d == {7'h05, 1'b1}, "R2 repeated start read", d, {7'h05, 1'b1});
    chk(sda_oe == 1'b0, "R2 bus released", sda_oe, 0);
  endtask

  initial begin
    t_power_up;
    t_bad_address;
    t_volatile;
    t_write_protect;
    t_program;
    t_extra_byte;
    t_framing;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule